// File: doc/BRIEF.md
# Consumed Frame Acceptance Checker

This block judges whether a consumed-data frame that has just finished arriving may be accepted. It sits beside the receive path. It watches the stream of received bytes, each with its byte index, together with the kind of variable that was identified earlier in the exchange. From that stream it captures the control, PDU-type and length fields. When the receiver signals the end of the frame, the block compares the captured fields against fixed constants and against the final byte count.

The end of a frame is announced by one of two single-cycle pulses. The first, `end_good_p`, says the frame check sequence and line coding were correct. The second, `end_bad_p`, says one of them failed. The block raises `frame_ok_p` in the same cycle as a good end when every field matches.

The length comparison is kept apart from the acceptance decision and runs at every frame end, good or bad. Its result appears on `len_ok`, and any mismatch latches `len_err` until software-side logic clears it through `err_clr`. A length fault is therefore visible on its own and is never hidden behind a checksum failure.

A small state machine follows the header. It has three states:
- `ST_HUNT`: no control byte seen yet.
- `ST_HEADER`: a control byte has been captured.
- `ST_BODY`: a length byte has been captured after the control byte.

It has three transitions:
- start: a valid byte at index 0 moves it to `ST_HEADER` from any state.
- length-seen: a valid byte at index 3 while in `ST_HEADER` moves it to `ST_BODY`.
- frame-end: either end pulse returns it to `ST_HUNT`.

Top module: `cons_frame_gate`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `frame_ok_p`, `len_ok` and `len_err` are 0, and all captured fields and the state machine are cleared.
- R2: The byte with index 0 and `byte_vld` high is taken as the control byte; acceptance requires it to equal 0x02.
- R3: The byte with index 1 and `byte_vld` high is taken as the PDU-type byte; acceptance requires it to equal 0x40.
- R4: The byte with index 3 and `byte_vld` high is the length byte L. The length matches when `byte_idx` at the frame-end cycle equals L+5, computed without wrap-around; L=255 never matches an 8-bit index.
- R5: Acceptance requires `var_id` to be 1 (consumed variable 1), 2 (consumed variable 2) or 3 (reset variable); codes 0 and 4 to 7 reject the frame.
- R6: `frame_ok_p` is high only in a cycle where `end_good_p` is high and `end_bad_p` is low, and all of R2 to R5 hold and the state is `ST_BODY`. It is never high on two consecutive cycles.
- R7: On every frame end, good or bad, `len_ok` is loaded in the next cycle with the length-match result alone, whatever the checksum outcome; between frame ends it holds its value.
- R8: `len_err` becomes 1 the cycle after a frame end whose length does not match, and stays 1 until `err_clr` is high on a cycle with no such mismatch. A mismatch in the same cycle as `err_clr` wins, leaving `len_err` at 1.
- R9: Bytes presented with `byte_vld` low are ignored: they change neither the captured fields nor the state.
- R10: A frame end returns the state machine to `ST_HUNT`. A frame that ends before its length byte is captured (still in `ST_HUNT` or `ST_HEADER`) is rejected and counts as a length mismatch, even if a stale length from an earlier frame would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | Received byte strobe |
| byte_idx | input | IDX_W | Index of the current byte; at a frame end, the total byte count |
| byte_in | input | 8 | Received byte value |
| var_id | input | 3 | Kind of identified variable (encoding in R5) |
| end_good_p | input | 1 | Frame ended with correct check sequence and coding |
| end_bad_p | input | 1 | Frame ended with a check sequence or coding failure |
| err_clr | input | 1 | Clears the sticky length error |
| frame_ok_p | output | 1 | One-cycle frame accepted pulse |
| len_ok | output | 1 | Length-match result of the last frame end |
| len_err | output | 1 | Sticky length error |

## Verification
Two events can land in the same cycle here: the clearing of the sticky length error and a frame end that sets it. The bench drives `err_clr` in the very cycle of a mismatching frame end and expects `len_err` to stay high. It drives the clear on a matching frame end and expects it to fall. A second overlap is a frame end that carries both a checksum failure and a length fault. In that case the bench expects no acceptance but still the length error. A third is both end pulses at once, where acceptance must be withheld while the length is judged normally.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam logic [7:0] CTRL_RSP_DATA = 8'h02;
    localparam logic [7:0] PDU_PRODCONS  = 8'h40;
    localparam int         LEN_OVERHEAD  = 5;
    localparam int         POS_CTRL      = 0;
    localparam int         POS_PDU       = 1;
    localparam int         POS_LEN       = 3;

    typedef enum logic [2:0] {
        VAR_NONE     = 3'd0,
        VAR_CONS1    = 3'd1,
        VAR_CONS2    = 3'd2,
        VAR_RESET    = 3'd3,
        VAR_PROD     = 3'd4,
        VAR_PRESENCE = 3'd5,
        VAR_IDENT    = 3'd6,
        VAR_SPARE    = 3'd7
    } var_kind_t;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_HEADER = 2'd1,
        ST_BODY   = 2'd2
    } frm_state_t;
endpackage

// File: rtl/cfg_field_capture.sv
module cfg_field_capture
    import cfg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_in,
    output logic             ctrl_seen,
    output logic             len_seen,
    output logic [7:0]       ctrl_q,
    output logic [7:0]       pdu_q,
    output logic [7:0]       len_q
);
    logic pdu_seen;

    // Field strobes: a valid byte at the field's fixed position.
    always_comb begin
        ctrl_seen = byte_vld && (byte_idx == IDX_W'(POS_CTRL));
        pdu_seen  = byte_vld && (byte_idx == IDX_W'(POS_PDU));
        len_seen  = byte_vld && (byte_idx == IDX_W'(POS_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pdu_q  <= '0;
            len_q  <= '0;
        end else begin
            if (ctrl_seen) ctrl_q <= byte_in;
            if (pdu_seen)  pdu_q  <= byte_in;
            if (len_seen)  len_q  <= byte_in;
        end
    end

    // R9: a byte without its strobe leaves the captured control field alone
    p_idle_byte_r9: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable(ctrl_q));
endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
    import cfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_seen,
    input  logic len_seen,
    input  logic frame_end,
    output logic in_body
);
    frm_state_t state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // Next-state logic; frame end has priority over any byte.
    always_comb begin
        state_d = state_q;
        if (frame_end) begin
            state_d = ST_HUNT;
        end else if (ctrl_seen) begin
            state_d = ST_HEADER;
        end else begin
            unique case (state_q)
                ST_HUNT:   state_d = ST_HUNT;
                ST_HEADER: if (len_seen) state_d = ST_BODY;
                ST_BODY:   state_d = ST_BODY;
                default:   state_d = ST_HUNT;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_BODY: in_body = 1'b1;
            default: in_body = 1'b0;
        endcase
    end

    // R10: any frame end lands the machine in the hunt state
    p_hunt_after_end_r10: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (state_q == ST_HUNT));

    // R10: the body state is only entered from the header state
    p_body_from_header_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(in_body) |-> ($past(state_q) == ST_HEADER));
endmodule

// File: rtl/cons_frame_gate.sv
module cons_frame_gate
    import cfg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_in,
    input  logic [2:0]       var_id,
    input  logic             end_good_p,
    input  logic             end_bad_p,
    input  logic             err_clr,
    output logic             frame_ok_p,
    output logic             len_ok,
    output logic             len_err
);
    localparam int CMP_W = ((IDX_W > 8) ? IDX_W : 8) + 1;

    logic       ctrl_seen, len_seen, in_body, frame_end;
    logic [7:0] ctrl_q, pdu_q, len_q;
    logic       len_match, hdr_match, var_ok;
    logic       len_ok_q, len_err_q;

    assign frame_end = end_good_p | end_bad_p;

    cfg_field_capture #(.IDX_W(IDX_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_vld),
        .byte_idx  (byte_idx),
        .byte_in   (byte_in),
        .ctrl_seen (ctrl_seen),
        .len_seen  (len_seen),
        .ctrl_q    (ctrl_q),
        .pdu_q     (pdu_q),
        .len_q     (len_q)
    );

    cfg_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctrl_seen (ctrl_seen),
        .len_seen  (len_seen),
        .frame_end (frame_end),
        .in_body   (in_body)
    );

    // Field comparisons.
    always_comb begin
        len_match = in_body &&
            (CMP_W'(byte_idx) == (CMP_W'(len_q) + CMP_W'(LEN_OVERHEAD)));
        hdr_match = (ctrl_q == CTRL_RSP_DATA) && (pdu_q == PDU_PRODCONS);
        unique case (var_kind_t'(var_id))
            VAR_CONS1, VAR_CONS2, VAR_RESET: var_ok = 1'b1;
            default:                         var_ok = 1'b0;
        endcase
    end

    // Length flags: judged at every frame end, independent of the checksum.
    always_ff @(posedge clk) begin
        if (rst) begin
            len_ok_q  <= 1'b0;
            len_err_q <= 1'b0;
        end else begin
            if (frame_end) len_ok_q <= len_match;
            if (frame_end && !len_match) len_err_q <= 1'b1;
            else if (err_clr)            len_err_q <= 1'b0;
        end
    end

    always_comb begin
        frame_ok_p = !rst && end_good_p && !end_bad_p && hdr_match && var_ok && len_match;
        len_ok     = len_ok_q;
        len_err    = len_err_q;
    end

    // R6: acceptance only alongside a clean frame end
    p_ok_needs_good_r6: assert property (@(posedge clk) disable iff (rst)
        frame_ok_p |-> (end_good_p && !end_bad_p));

    // R6: never two accepted cycles in a row
    p_ok_single_r6: assert property (@(posedge clk) disable iff (rst)
        frame_ok_p |=> !frame_ok_p);

    // R4: an accepted frame always reports a matching length
    p_ok_len_r4: assert property (@(posedge clk) disable iff (rst)
        frame_ok_p |=> len_ok);

    // R7: the length flag only moves at frame ends
    p_lenok_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(len_ok));

    // R8: the sticky error survives until a clear
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (len_err && !err_clr) |=> len_err);

    // R8: an accepted frame cannot raise the error
    p_err_not_on_ok_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_ok_p && !len_err) |=> !len_err);
endmodule

// File: tb/test_cons_frame_gate.sv
module test_cons_frame_gate;
    localparam int IDX_W = 8;

    typedef struct {
        bit    ok;
        bit    lok;
        bit    lerr;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             byte_vld = 1'b0;
    logic [IDX_W-1:0] byte_idx = '0;
    logic [7:0]       byte_in = '0;
    logic [2:0]       var_id = '0;
    logic             end_good_p = 1'b0;
    logic             end_bad_p = 1'b0;
    logic             err_clr = 1'b0;
    logic             frame_ok_p, len_ok, len_err;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    bit   exp_err  = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    cons_frame_gate #(.IDX_W(IDX_W)) i_cons_frame_gate (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .byte_idx   (byte_idx),
        .byte_in    (byte_in),
        .var_id     (var_id),
        .end_good_p (end_good_p),
        .end_bad_p  (end_bad_p),
        .err_clr    (err_clr),
        .frame_ok_p (frame_ok_p),
        .len_ok     (len_ok),
        .len_err    (len_err)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver: plays one frame and pushes the expected outcome.
    task automatic send_frame(input logic [7:0] ctrl, input logic [7:0] pdu,
                              input logic [7:0] len, input logic [2:0] v,
                              input int nbytes, input int endidx,
                              input bit good, input bit bad, input bit clr,
                              input bit noise, input string tag);
        exp_t e;
        bit   lm;
        lm = (nbytes >= 4) && (endidx == int'(len) + 5);
        e.ok  = good && !bad && ctrl == 8'h02 && pdu == 8'h40 &&
                v >= 3'd1 && v <= 3'd3 && lm;
        e.lok = lm;
        exp_err = lm ? (exp_err && !clr) : 1'b1;
        e.lerr = exp_err;
        e.tag  = tag;
        var_id = v;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_idx = IDX_W'(i);
            byte_in  = (i == 0) ? ctrl : (i == 1) ? pdu : (i == 3) ? len : 8'hA5;
        end
        if (noise) begin
            @(negedge clk);
            byte_vld = 1'b0;
            byte_idx = '0;
            byte_in  = 8'hFF;
        end
        sb_q.push_back(e);
        @(negedge clk);
        byte_vld   = 1'b0;
        byte_idx   = IDX_W'(endidx);
        byte_in    = 8'h00;
        end_good_p = good;
        end_bad_p  = bad;
        err_clr    = clr;
        @(negedge clk);
        end_good_p = 1'b0;
        end_bad_p  = 1'b0;
        err_clr    = 1'b0;
        byte_idx   = '0;
        @(negedge clk);
    endtask

    // Monitor: compares results as the design produces them.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (!rst && (end_good_p || end_bad_p)) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected frame end", 0, 1);
                end else begin
                    e = sb_q.pop_front();
                    check(frame_ok_p == e.ok, e.tag, "frame_ok_p", frame_ok_p, e.ok);
                    @(negedge clk);
                    #1;
                    check(len_ok == e.lok, e.tag, "len_ok", len_ok, e.lok);
                    check(len_err == e.lerr, e.tag, "len_err", len_err, e.lerr);
                end
            end else if (!rst && frame_ok_p) begin
                check(1'b0, "R6", "frame_ok_p outside frame end", 1, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "WDOG", "timeout", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with an end pulse presented during reset
        @(negedge clk);
        end_good_p = 1'b1;
        byte_idx   = IDX_W'(5);
        #1;
        check(frame_ok_p == 1'b0, "R1", "frame_ok_p in reset", frame_ok_p, 0);
        @(negedge clk);
        end_good_p = 1'b0;
        byte_idx   = '0;
        rst        = 1'b0;
        #1;
        check(len_ok == 1'b0, "R1", "len_ok after reset", len_ok, 0);
        check(len_err == 1'b0, "R1", "len_err after reset", len_err, 0);
        check(frame_ok_p == 1'b0, "R1", "frame_ok_p after reset", frame_ok_p, 0);

        send_frame(8'h02, 8'h40, 8'd4, 3'd1, 9, 9, 1, 0, 0, 0, "R6 cons1");
        send_frame(8'h02, 8'h40, 8'd6, 3'd2, 11, 11, 1, 0, 0, 0, "R5 cons2");
        send_frame(8'h02, 8'h40, 8'd0, 3'd3, 5, 5, 1, 0, 0, 0, "R5 reset var");
        send_frame(8'h02, 8'h40, 8'd4, 3'd4, 9, 9, 1, 0, 0, 0, "R5 produced var");
        send_frame(8'h02, 8'h40, 8'd4, 3'd0, 9, 9, 1, 0, 0, 0, "R5 no var");
        send_frame(8'h03, 8'h40, 8'd4, 3'd1, 9, 9, 1, 0, 0, 0, "R2 bad ctrl");
        send_frame(8'h02, 8'h41, 8'd4, 3'd1, 9, 9, 1, 0, 0, 0, "R3 bad pdu");
        send_frame(8'h02, 8'h40, 8'd4, 3'd1, 10, 10, 1, 0, 0, 0, "R4 R8 length mismatch");
        send_frame(8'h02, 8'h40, 8'd4, 3'd1, 9, 9, 0, 1, 1, 0, "R7 bad crc good length clear");
        send_frame(8'h02, 8'h40, 8'd4, 3'd1, 8, 8, 0, 1, 0, 0, "R7 bad crc bad length");
        send_frame(8'h02, 8'h40, 8'd4, 3'd1, 12, 12, 1, 0, 1, 0, "R8 clear with mismatch");

        // R8: stand-alone clear
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        exp_err = 1'b0;
        #1;
        check(len_err == 1'b0, "R8", "len_err after clear", len_err, 0);

        send_frame(8'h02, 8'h40, 8'd4, 3'd1, 9, 9, 1, 0, 0, 1, "R9 ignored idle byte");
        send_frame(8'h02, 8'h40, 8'd4, 3'd1, 2, 9, 1, 0, 0, 0, "R10 end before length");
        send_frame(8'h02, 8'h40, 8'd255, 3'd1, 4, 4, 1, 0, 0, 0, "R4 no wrap at 255");
        send_frame(8'h02, 8'h40, 8'd4, 3'd1, 9, 9, 1, 1, 1, 0, "R6 both end pulses");
        send_frame(8'h02, 8'h40, 8'd250, 3'd2, 255, 255, 1, 0, 0, 0, "R4 longest frame");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R6", "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule